// File: doc/BRIEF.md
# Descriptor-Ring Audio Playback DMA

This block is one bus-master playback channel for an audio path. Software builds a ring of 32 buffer descriptors in memory. Each descriptor names a sample buffer, says how many 16-bit samples it holds, and carries a command word. Software then gives the engine the ring's base address and a last-valid index, and sets the run bit. The engine walks the ring one descriptor at a time. It reads each sample buffer through a one-outstanding memory-read port and sends the samples, one per beat, on a ready/valid stream to the audio sink.

Progress is shown at all times as a current index and a count of samples left in that descriptor. The two values always change in the same cycle. A descriptor whose command word carries the completion flag sets a sticky completion status bit when it finishes, and that bit drives an interrupt when interrupts are enabled. The engine never passes the last-valid index. It halts there and sets a last-valid-reached status bit. If the run bit is still set and software moves the last-valid index, the engine carries on with the next descriptor. Software can therefore keep the ring running without end by keeping the last-valid index one behind the current index.

The walk is a single state machine with eight named states. ST_HALT is idle or stopped. ST_FETCH_ADDR and ST_FETCH_CMD read the two descriptor words into a pending holder. ST_LOAD commits the pending descriptor: the index and count change there together. ST_FETCH_DATA reads one 32-bit sample word. ST_SEND_LO and ST_SEND_HI present its two halves. ST_RETIRE finishes a descriptor.

The transitions are these:
- ST_HALT to ST_FETCH_ADDR when run is set, no reset is pending, and no descriptor is loaded. This is not taken when the finished descriptor is the last-valid one.
- ST_HALT to ST_FETCH_DATA or ST_RETIRE when resuming a loaded descriptor.
- Each fetch state advances on a memory response. ST_FETCH_ADDR goes to ST_FETCH_CMD, ST_FETCH_CMD goes to ST_LOAD, and ST_FETCH_DATA goes to ST_SEND_LO.
- ST_LOAD goes to ST_RETIRE for a zero count. Otherwise it goes to ST_FETCH_DATA, or to ST_HALT if run is clear.
- ST_SEND_LO goes to ST_SEND_HI or ST_RETIRE on an accepted beat.
- ST_SEND_HI goes to ST_FETCH_DATA, ST_HALT or ST_RETIRE on an accepted beat.
- ST_RETIRE goes to ST_HALT when the last-valid index is reached or run is clear. Otherwise it goes to ST_FETCH_ADDR for the next index.

Top module: `dma_ring_engine`

## Requirements
- R1: The ring has 32 entries. The current index only ever steps by one, and it wraps from 31 to 0. Descriptor i is read at base + 8*i.
- R2: Descriptor layout, as 32-bit little-endian words:
  - The word at base + 8*i is the byte address of the sample buffer.
  - The word at base + 8*i + 4 holds the sample count in bits 15:0 and the command in bits 31:16.
  - Samples are sent in buffer order, with the low half of each 32-bit word first. An odd count leaves the last upper half unused.
- R3: The completion flag is command bit 15 (word bit 31). When a descriptor with this flag finishes, `st_done` is set. A descriptor without it leaves `st_done` unchanged. `irq` is high exactly when `st_done` and the interrupt-enable control bit are both set.
- R4: Status bits clear only when 1 is written to them with select 3: bit 0 clears `st_done` and bit 1 clears `st_lvr`. Writing 0 to a bit leaves it unchanged.
- R5: Clearing the run bit stops the engine at the next sample-word or descriptor boundary, and `st_halted` is then set. While halted there is no stream beat, no memory request, and the position holds. Setting run again resumes with no sample lost or repeated.
- R6: Writing control bit 2 requests a register reset. The request waits while the engine is running. Once the engine is halted, base, last-valid index, control, status, index and position all clear, and the request bit (`ctrl_rst_busy`) clears itself.
- R7: `remaining` falls by exactly one per accepted sample. When `cur_idx` changes to a new descriptor, `remaining` shows that descriptor's full count in the same cycle.
- R8: After finishing the descriptor whose index equals the last-valid index, the engine halts and sets `st_lvr`. If run is still set, writing a different last-valid index resumes the walk at the next descriptor.
- R9: While `m_tvalid` is high and `m_tready` is low, `m_tvalid` and `m_tdata` hold. No sample is dropped or sent twice.
- R10: A descriptor with a count of zero finishes without producing any stream beat.
- R11: After reset the engine is halted, with index 0, position 0, all status clear, and no request or beat.
- R12: Register writes use `cfg_sel` to pick the target:
  - 0 selects the base address.
  - 1 selects the last-valid index, in the low 5 bits.
  - 2 selects control: bit 0 run, bit 1 interrupt enable, bit 2 register reset.
  - 3 selects status clear.
  Each write takes effect at the clock edge where `cfg_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 base, 1 last-valid, 2 control, 3 status clear) |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Read request, held until the response |
| mem_addr | output | 32 | Read byte address |
| mem_rvalid | input | 1 | Read response strobe |
| mem_rdata | input | 32 | Read response data |
| m_tvalid | output | 1 | Sample valid |
| m_tready | input | 1 | Sink ready |
| m_tdata | output | 16 | Sample |
| cur_idx | output | 5 | Descriptor in progress |
| remaining | output | 16 | Samples left in that descriptor |
| st_halted | output | 1 | Engine is stopped |
| st_done | output | 1 | Completion status (sticky) |
| st_lvr | output | 1 | Last-valid-reached status (sticky) |
| ctrl_run | output | 1 | Run bit as written |
| ctrl_rst_busy | output | 1 | Register reset pending |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest case to reach from the ports is a run-bit clear that lands in the middle of a long descriptor while the sink is applying backpressure. The engine must finish the word it holds, park with a partial count, and later resume without losing or repeating a sample. The stimulus polls the position until the engine is well inside a 20-sample descriptor, then drops run. It then checks that the halted position is even and stays frozen, and that every queued sample still arrives in order after resumption. A register reset requested while the engine is streaming is the other awkward case. The stimulus writes it during the stream and checks that it stays pending until the last-valid halt.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_FETCH_ADDR,
        ST_FETCH_CMD,
        ST_LOAD,
        ST_FETCH_DATA,
        ST_SEND_LO,
        ST_SEND_HI,
        ST_RETIRE
    } walk_state_t;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_LAST = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_t;

    localparam int CTRL_RUN  = 0;
    localparam int CTRL_IE   = 1;
    localparam int CTRL_RST  = 2;
    localparam int STAT_DONE = 0;
    localparam int STAT_LVR  = 1;
    localparam int CMD_IOC   = 15;
    localparam int CNT_W     = 16;
    localparam int SMP_W     = 16;
    localparam int WORD_W    = 32;

endpackage

// File: rtl/dma_ring_regs.sv
module dma_ring_regs
    import dma_ring_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int AW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              halted,
    input  logic              set_done,
    input  logic              set_lvr,
    output logic [AW-1:0]     base,
    output logic [IDX_W-1:0]  lvi,
    output logic              run,
    output logic              ie,
    output logic              rst_pend,
    output logic              soft_clr,
    output logic              st_done,
    output logic              st_lvr
);

    logic wr_base, wr_last, wr_ctrl, wr_stat;

    always_comb begin
        wr_base = cfg_wr && (reg_sel_t'(cfg_sel) == SEL_BASE);
        wr_last = cfg_wr && (reg_sel_t'(cfg_sel) == SEL_LAST);
        wr_ctrl = cfg_wr && (reg_sel_t'(cfg_sel) == SEL_CTRL);
        wr_stat = cfg_wr && (reg_sel_t'(cfg_sel) == SEL_STAT);
    end

    // register reset only acts once the walker is parked
    assign soft_clr = rst_pend & halted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base     <= '0;
            lvi      <= '0;
            run      <= 1'b0;
            ie       <= 1'b0;
            rst_pend <= 1'b0;
            st_done  <= 1'b0;
            st_lvr   <= 1'b0;
        end else if (soft_clr) begin
            base     <= '0;
            lvi      <= '0;
            run      <= 1'b0;
            ie       <= 1'b0;
            rst_pend <= 1'b0;
            st_done  <= 1'b0;
            st_lvr   <= 1'b0;
        end else begin
            if (wr_base) base <= cfg_wdata[AW-1:0];
            if (wr_last) lvi  <= cfg_wdata[IDX_W-1:0];
            if (wr_ctrl) begin
                run <= cfg_wdata[CTRL_RUN];
                ie  <= cfg_wdata[CTRL_IE];
                if (cfg_wdata[CTRL_RST]) rst_pend <= 1'b1;
            end
            // a new set wins over a simultaneous write-one-to-clear
            st_done <= set_done | (st_done & ~(wr_stat & cfg_wdata[STAT_DONE]));
            st_lvr  <= set_lvr  | (st_lvr  & ~(wr_stat & cfg_wdata[STAT_LVR]));
        end
    end

endmodule

// File: rtl/dma_ring_walker.sv
module dma_ring_walker
    import dma_ring_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int AW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              run,
    input  logic              rst_pend,
    input  logic [AW-1:0]     base,
    input  logic [IDX_W-1:0]  lvi,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [SMP_W-1:0]  m_tdata,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [CNT_W-1:0]  remaining,
    output logic              halted,
    output logic              set_done,
    output logic              set_lvr
);

    localparam int DESC_SHIFT = 3;             // 8 bytes per descriptor
    localparam int WORD_BYTES = WORD_W / 8;

    walk_state_t state, nxt;

    logic [IDX_W-1:0]  fidx;
    logic [AW-1:0]     pend_addr, buf_ptr;
    logic [CNT_W-1:0]  pend_cnt;
    logic              pend_ioc, cmd_ioc;
    logic [WORD_W-1:0] word;
    logic              ld, fin;

    logic at_last, last_beat, beat;
    assign at_last   = (cur_idx == lvi);
    assign last_beat = (remaining == CNT_W'(1));
    assign beat      = m_tvalid & m_tready;

    // next-state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HALT: begin
                if (run && !rst_pend) begin
                    if (ld)
                        nxt = (remaining == '0) ? ST_RETIRE : ST_FETCH_DATA;
                    else if (!(fin && at_last))
                        nxt = ST_FETCH_ADDR;
                end
            end
            ST_FETCH_ADDR: if (mem_rvalid) nxt = ST_FETCH_CMD;
            ST_FETCH_CMD:  if (mem_rvalid) nxt = ST_LOAD;
            ST_LOAD: begin
                if (pend_cnt == '0) nxt = ST_RETIRE;
                else                nxt = run ? ST_FETCH_DATA : ST_HALT;
            end
            ST_FETCH_DATA: if (mem_rvalid) nxt = ST_SEND_LO;
            ST_SEND_LO: if (m_tready) nxt = last_beat ? ST_RETIRE : ST_SEND_HI;
            ST_SEND_HI: begin
                if (m_tready) begin
                    if (last_beat) nxt = ST_RETIRE;
                    else           nxt = run ? ST_FETCH_DATA : ST_HALT;
                end
            end
            ST_RETIRE: nxt = (at_last || !run) ? ST_HALT : ST_FETCH_ADDR;
            default:   nxt = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        mem_req  = 1'b0;
        mem_addr = '0;
        m_tvalid = 1'b0;
        m_tdata  = '0;
        halted   = 1'b0;
        set_done = 1'b0;
        set_lvr  = 1'b0;
        unique case (state)
            ST_HALT:       halted = 1'b1;
            ST_FETCH_ADDR: begin
                mem_req  = 1'b1;
                mem_addr = base + (AW'(fidx) << DESC_SHIFT);
            end
            ST_FETCH_CMD:  begin
                mem_req  = 1'b1;
                mem_addr = base + (AW'(fidx) << DESC_SHIFT) + AW'(WORD_BYTES);
            end
            ST_LOAD:       ;
            ST_FETCH_DATA: begin
                mem_req  = 1'b1;
                mem_addr = buf_ptr;
            end
            ST_SEND_LO:    begin
                m_tvalid = 1'b1;
                m_tdata  = word[SMP_W-1:0];
            end
            ST_SEND_HI:    begin
                m_tvalid = 1'b1;
                m_tdata  = word[WORD_W-1:SMP_W];
            end
            ST_RETIRE:     begin
                set_done = cmd_ioc;
                set_lvr  = at_last;
            end
            default:       ;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_idx   <= '0;
            remaining <= '0;
            fidx      <= '0;
            pend_addr <= '0;
            pend_cnt  <= '0;
            pend_ioc  <= 1'b0;
            cmd_ioc   <= 1'b0;
            buf_ptr   <= '0;
            word      <= '0;
            ld        <= 1'b0;
            fin       <= 1'b0;
        end else if (soft_clr) begin
            cur_idx   <= '0;
            remaining <= '0;
            ld        <= 1'b0;
            fin       <= 1'b0;
        end else begin
            if (state == ST_HALT && nxt == ST_FETCH_ADDR)
                fidx <= fin ? cur_idx + 1'b1 : cur_idx;
            if (state == ST_RETIRE && nxt == ST_FETCH_ADDR)
                fidx <= cur_idx + 1'b1;
            if (state == ST_FETCH_ADDR && mem_rvalid)
                pend_addr <= mem_rdata[AW-1:0];
            if (state == ST_FETCH_CMD && mem_rvalid) begin
                pend_cnt <= mem_rdata[CNT_W-1:0];
                pend_ioc <= mem_rdata[CNT_W + CMD_IOC];
            end
            if (state == ST_LOAD) begin
                // index and position commit in the same edge
                cur_idx   <= fidx;
                remaining <= pend_cnt;
                buf_ptr   <= pend_addr;
                cmd_ioc   <= pend_ioc;
                ld        <= 1'b1;
                fin       <= 1'b0;
            end
            if (state == ST_FETCH_DATA && mem_rvalid) begin
                word    <= mem_rdata;
                buf_ptr <= buf_ptr + AW'(WORD_BYTES);
            end
            if (beat)
                remaining <= remaining - CNT_W'(1);
            if (state == ST_RETIRE) begin
                ld  <= 1'b0;
                fin <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_ring_engine.sv
module dma_ring_engine
    import dma_ring_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int AW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [15:0]       m_tdata,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [15:0]       remaining,
    output logic              st_halted,
    output logic              st_done,
    output logic              st_lvr,
    output logic              ctrl_run,
    output logic              ctrl_rst_busy,
    output logic              irq
);

    logic [AW-1:0]    base;
    logic [IDX_W-1:0] lvi;
    logic             ie, soft_clr, set_done, set_lvr;

    dma_ring_regs #(.IDX_W(IDX_W), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .halted    (st_halted),
        .set_done  (set_done),
        .set_lvr   (set_lvr),
        .base      (base),
        .lvi       (lvi),
        .run       (ctrl_run),
        .ie        (ie),
        .rst_pend  (ctrl_rst_busy),
        .soft_clr  (soft_clr),
        .st_done   (st_done),
        .st_lvr    (st_lvr)
    );

    dma_ring_walker #(.IDX_W(IDX_W), .AW(AW)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_clr   (soft_clr),
        .run        (ctrl_run),
        .rst_pend   (ctrl_rst_busy),
        .base       (base),
        .lvi        (lvi),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .m_tvalid   (m_tvalid),
        .m_tready   (m_tready),
        .m_tdata    (m_tdata),
        .cur_idx    (cur_idx),
        .remaining  (remaining),
        .halted     (st_halted),
        .set_done   (set_done),
        .set_lvr    (set_lvr)
    );

    assign irq = st_done & ie;

endmodule

// File: rtl/dma_ring_chk.sv
module dma_ring_chk #(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             m_tvalid,
    input logic             m_tready,
    input logic [15:0]      m_tdata,
    input logic [IDX_W-1:0] cur_idx,
    input logic [15:0]      remaining,
    input logic             st_halted,
    input logic             st_done,
    input logic             st_lvr,
    input logic             ctrl_rst_busy
);

    p_idx_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_idx != $past(cur_idx)) && !$past(ctrl_rst_busy)
        |-> cur_idx == IDX_W'($past(cur_idx) + 1'b1));

    p_done_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_done) |-> $past(remaining) == 16'd0);

    p_halt_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_halted |-> !m_tvalid && !mem_req);

    p_rst_waits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rst_busy && !st_halted |=> ctrl_rst_busy);

    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && m_tready |=> remaining == $past(remaining) - 16'd1);

    p_lvr_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_lvr) |-> st_halted);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata));

endmodule

bind dma_ring_engine dma_ring_chk #(.IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req       (mem_req),
    .m_tvalid      (m_tvalid),
    .m_tready      (m_tready),
    .m_tdata       (m_tdata),
    .cur_idx       (cur_idx),
    .remaining     (remaining),
    .st_halted     (st_halted),
    .st_done       (st_done),
    .st_lvr        (st_lvr),
    .ctrl_rst_busy (ctrl_rst_busy)
);

// File: tb/sim_dma_ring_engine.sv
module sim_dma_ring_engine;

    localparam int IDX_W = 5;
    localparam int AW    = 32;
    localparam int MEMW  = 2048;
    localparam logic [31:0] BASE = 32'h100;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [1:0]       cfg_sel = '0;
    logic [31:0]      cfg_wdata = '0;
    logic             mem_req;
    logic [AW-1:0]    mem_addr;
    logic             mem_rvalid;
    logic [31:0]      mem_rdata;
    logic             m_tvalid;
    logic             m_tready = 1'b1;
    logic [15:0]      m_tdata;
    logic [IDX_W-1:0] cur_idx;
    logic [15:0]      remaining;
    logic             st_halted, st_done, st_lvr, ctrl_run, ctrl_rst_busy, irq;

    always #4 clk = ~clk;

    dma_ring_engine #(.IDX_W(IDX_W), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .m_tvalid(m_tvalid),
        .m_tready(m_tready), .m_tdata(m_tdata), .cur_idx(cur_idx),
        .remaining(remaining), .st_halted(st_halted), .st_done(st_done),
        .st_lvr(st_lvr), .ctrl_run(ctrl_run), .ctrl_rst_busy(ctrl_rst_busy),
        .irq(irq)
    );

    int          checks = 0;
    int          errors = 0;
    logic [15:0] exp_q[$];
    logic [31:0] mem [MEMW];
    int          dcnt [32];
    int          dgen [32];
    bit          idx_watch = 1'b0;
    bit          bp_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [IDX_W-1:0] prev_idx = '0;
    bit          finished = 1'b0;

    // memory model: one outstanding read, fixed latency
    logic        mpend;
    logic [10:0] mpa;
    int          mlat;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            mpend      <= 1'b0;
            mpa        <= '0;
            mlat       <= 0;
        end else begin
            mem_rvalid <= 1'b0;
            if (mpend) begin
                if (mlat == 0) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= mem[mpa];
                    mpend      <= 1'b0;
                end else begin
                    mlat <= mlat - 1;
                end
            end else if (mem_req && !mem_rvalid) begin
                mpend <= 1'b1;
                mpa   <= mem_addr[12:2];
                mlat  <= 1;
            end
        end
    end

    // sink ready pattern, changed just after each rising edge
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        m_tready = bp_en ? (lfsr[0] | lfsr[5]) : 1'b1;
    end

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (m_tvalid && m_tready) begin
                if (exp_q.size() == 0) begin
                    check("R9", "unexpected sample", m_tdata, -1);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check("R2", "sample value", m_tdata, e);
                end
            end
            if (idx_watch && cur_idx != prev_idx)
                check("R7", "count at index change", remaining, dcnt[cur_idx]);
            prev_idx = cur_idx;
        end
    end

    function automatic logic [15:0] smp(input int i, input int k, input int g);
        return 16'(g * 4096 + i * 64 + k);
    endfunction

    task automatic set_desc(input int i, input int cnt, input bit ioc, input int g);
        int baddr, w;
        baddr = 'h1000 + i * 'h40;
        mem[(BASE + i * 8) >> 2]     = 32'(baddr);
        mem[(BASE + i * 8 + 4) >> 2] = {ioc, 15'd0, 16'(cnt)};
        for (int k = 0; k < cnt; k++) begin
            w = (baddr >> 2) + k / 2;
            if (k % 2 == 0) mem[w][15:0]  = smp(i, k, g);
            else            mem[w][31:16] = smp(i, k, g);
        end
        dcnt[i] = cnt;
        dgen[i] = g;
    endtask

    task automatic expect_desc(input int i);
        for (int k = 0; k < dcnt[i]; k++) exp_q.push_back(smp(i, k, dgen[i]));
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
        @(posedge clk); #2;
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk); #2;
        cfg_wr = 1'b0;
    endtask

    task automatic wait_stop(input bit need_lvr, input int limit);
        repeat (4) @(negedge clk);
        for (int c = 0; c < limit; c++) begin
            @(negedge clk);
            if (st_halted && (!need_lvr || st_lvr) && exp_q.size() == 0) break;
        end
    endtask

    initial begin
        for (int a = 0; a < MEMW; a++) mem[a] = '0;
        for (int a = 0; a < 32; a++) begin dcnt[a] = 0; dgen[a] = 0; end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11", "halted", st_halted, 1);
        check("R11", "index", cur_idx, 0);
        check("R11", "remaining", remaining, 0);
        check("R11", "tvalid", m_tvalid, 0);
        check("R11", "mem_req", mem_req, 0);
        check("R11", "status", {st_done, st_lvr}, 0);

        // first pass: odd count, zero count, flag on descriptor 1 only (R2 R3 R10 R12)
        set_desc(0, 4, 0, 1);
        set_desc(1, 3, 1, 1);
        set_desc(2, 0, 0, 1);
        set_desc(3, 5, 0, 1);
        for (int i = 0; i < 4; i++) expect_desc(i);
        idx_watch = 1'b1;
        cfg(2'd0, BASE);
        cfg(2'd1, 32'd3);
        cfg(2'd2, 32'h3);
        wait_stop(1'b1, 2000);
        check("R8", "lvr after stop", st_lvr, 1);
        check("R8", "halted at last", st_halted, 1);
        check("R10", "queue drained", exp_q.size(), 0);
        check("R1", "index at last", cur_idx, 3);
        check("R7", "remaining at end", remaining, 0);
        check("R3", "done status", st_done, 1);
        check("R3", "irq enabled", irq, 1);

        // irq gating and write-one-to-clear (R3 R4)
        cfg(2'd2, 32'h1);
        @(negedge clk);
        check("R3", "irq masked", irq, 0);
        cfg(2'd3, 32'h0);
        @(negedge clk);
        check("R4", "zero write keeps done", st_done, 1);
        cfg(2'd3, 32'h1);
        @(negedge clk);
        check("R4", "done cleared", st_done, 0);
        check("R4", "lvr kept", st_lvr, 1);
        cfg(2'd3, 32'h2);
        @(negedge clk);
        check("R4", "lvr cleared", st_lvr, 0);

        // move last-valid with run still set: resumes at 4 (R8), no flags (R3)
        set_desc(4, 2, 0, 2);
        set_desc(5, 6, 0, 2);
        set_desc(6, 1, 0, 2);
        for (int i = 4; i < 7; i++) expect_desc(i);
        cfg(2'd1, 32'd6);
        wait_stop(1'b1, 2000);
        check("R8", "resumed to new last", cur_idx, 6);
        check("R3", "no flag no status", st_done, 0);
        check("R8", "queue drained", exp_q.size(), 0);
        cfg(2'd3, 32'h3);

        // wrap around the ring under backpressure (R1 R9)
        bp_en = 1'b1;
        for (int i = 7; i < 32; i++) set_desc(i, 1 + (i % 3), 0, 3);
        set_desc(0, 3, 0, 4);
        set_desc(1, 2, 0, 4);
        for (int i = 7; i < 32; i++) expect_desc(i);
        expect_desc(0);
        expect_desc(1);
        cfg(2'd1, 32'd1);
        wait_stop(1'b1, 20000);
        check("R1", "wrapped index", cur_idx, 1);
        check("R9", "queue drained", exp_q.size(), 0);
        cfg(2'd3, 32'h3);

        // run cleared mid-descriptor (R5)
        set_desc(2, 20, 0, 5);
        set_desc(3, 4, 0, 5);
        expect_desc(2);
        expect_desc(3);
        cfg(2'd1, 32'd3);
        for (int c = 0; c < 5000; c++) begin
            @(negedge clk);
            if (cur_idx == 2 && remaining <= 14 && remaining != 0) break;
        end
        cfg(2'd2, 32'h0);
        for (int c = 0; c < 2000; c++) begin
            @(negedge clk);
            if (st_halted) break;
        end
        begin
            logic [15:0] held;
            held = remaining;
            check("R5", "halted", st_halted, 1);
            check("R5", "index held", cur_idx, 2);
            check("R5", "partial count", held > 0, 1);
            check("R5", "word boundary", held % 2, 0);
            repeat (6) @(negedge clk);
            check("R5", "position frozen", remaining, held);
            check("R5", "no beat while halted", m_tvalid, 0);
        end
        cfg(2'd2, 32'h1);
        wait_stop(1'b1, 5000);
        check("R5", "all samples after resume", exp_q.size(), 0);
        check("R5", "reached last", cur_idx, 3);

        // register reset while halted (R6)
        idx_watch = 1'b0;
        bp_en = 1'b0;
        cfg(2'd2, 32'h4);
        repeat (2) @(negedge clk);
        check("R6", "request self-cleared", ctrl_rst_busy, 0);
        check("R6", "index cleared", cur_idx, 0);
        check("R6", "lvr cleared", st_lvr, 0);
        check("R6", "run cleared", ctrl_run, 0);

        // register reset requested while streaming waits for the halt (R6)
        cfg(2'd0, BASE);
        set_desc(0, 12, 1, 6);
        expect_desc(0);
        cfg(2'd1, 32'd0);
        cfg(2'd2, 32'h3);
        for (int c = 0; c < 2000; c++) begin
            @(negedge clk);
            if (m_tvalid) break;
        end
        cfg(2'd2, 32'h7);
        repeat (2) @(negedge clk);
        check("R6", "request pending while running", ctrl_rst_busy, 1);
        check("R6", "not halted yet", st_halted, 0);
        for (int c = 0; c < 2000; c++) begin
            @(negedge clk);
            if (!ctrl_rst_busy) break;
        end
        @(negedge clk);
        check("R6", "request done", ctrl_rst_busy, 0);
        check("R6", "samples delivered first", exp_q.size(), 0);
        check("R6", "done cleared by reset", st_done, 0);
        check("R6", "halted after reset", st_halted, 1);
        check("R6", "run cleared after reset", ctrl_run, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule